// File: doc/BRIEF.md
# Instruction-Snooping Coprocessor Front End

This block lets an arithmetic coprocessor share the host's instruction stream without being addressed as a peripheral. It watches every read on the shared bus that the host marks as an instruction fetch. It decodes the opcode nibble of that word, and when the word belongs to the coprocessor's reserved group it claims it with an acknowledge in the same cycle. The host treats a claimed word almost as a no-op. It takes a trap only when a reserved word goes unclaimed.

A claimed word either moves data or starts work. A coprocessor-load word makes the block latch the data word that the host reads from memory in its next bus cycle, and the host throws that value away. A coprocessor-store word makes the block supply the data for the host's next write cycle. A register-operation word starts a fixed-length execution engine on the block's four internal 16-bit registers. While that engine is running, any further claimed word is held back with a stall. The host must keep presenting the same fetch until the stall drops, and fetches the block does not claim pass through without delay.

Instruction word layout (16 bits): bits 15..12 opcode, 11..10 sub-operation, 9..8 destination register, 7..6 source register, 5..4 function, 3..0 unused.

Top module: `cop_snoop`

## Requirements
- R1: After reset every output is low, the engine is idle and all four registers hold zero.
- R2: `cop_ack` is high in exactly those cycles in which `bus_valid`=1, `bus_write`=0, `bus_ifetch`=1, bits 15..12 of `bus_rdata` equal 0xF and bits 11..10 are not 2'b11. A read with `bus_ifetch`=0 is never claimed, whatever its contents.
- R3: A fetched word whose opcode is not 0xF, or whose sub-operation (bits 11..10) is 2'b11, leaves `cop_ack` low and changes no state.
- R4: A claimed word with sub-operation 2'b00 (load) that is accepted makes the block capture `bus_rdata` into the register named by bits 9..8, if the next cycle with `bus_valid`=1 is a read with `bus_ifetch`=0.
- R5: A pending load or store is dropped if the next cycle with `bus_valid`=1 is not of the matching kind (data read for a load, write for a store); that cycle is then not used and no register changes.
- R6: For an accepted word with sub-operation 2'b01 (store), the next cycle with `bus_valid`=1 and `bus_write`=1 raises `cop_wdata_en` and drives `cop_wdata` with the register named by bits 7..6. At all other times `cop_wdata_en` and `cop_wdata` are zero.
- R7: An accepted word with sub-operation 2'b10 holds `cop_busy` high for exactly 8 cycles starting the next cycle. It then writes dst op src into the destination register (bits 9..8) as the flag falls, using operand values from the accept cycle. Function bits 5..4 select 00 add, 01 subtract (dst minus src), 10 AND, 11 XOR.
- R8: A claimed word presented while `cop_busy` is high raises `cop_stall` together with `cop_ack` and is not accepted. It is accepted in the first cycle it is presented with `cop_busy` low.
- R9: A fetch the block does not claim never raises `cop_stall`, even while the engine runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus transfer takes place this cycle |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_ifetch | input | 1 | Read is an instruction fetch |
| bus_rdata | input | 16 | Word returned by memory on reads |
| cop_ack | output | 1 | Fetched word claimed by the coprocessor |
| cop_stall | output | 1 | Hold the current fetch; engine still busy |
| cop_busy | output | 1 | Execution engine running |
| cop_wdata_en | output | 1 | Coprocessor is supplying write data this cycle |
| cop_wdata | output | 16 | Store data driven for the host's write |

## Verification
The hardest situation to reach is a claimed word arriving while the engine is still running, because it needs a register operation to be accepted first. The next claimed fetch then has to land inside the 8-cycle window. The stimulus issues a register operation and immediately fetches a store of the same register, holding that fetch through every stall cycle. This shows both the back-pressure and that the stored value is the finished result. A separate run puts ordinary fetches and data reads inside the busy window to show they pass unstalled, and abandoned load and store slots are followed by stores that expose the untouched registers.

// File: rtl/cop_snoop_pkg.sv
package cop_snoop_pkg;
  localparam int WORD_W = 16;
  localparam int OPC_W  = 4;
  localparam int RIDX_W = 2;
  localparam int NREGS  = 1 << RIDX_W;

  typedef enum logic [1:0] {
    SUB_LOAD  = 2'b00,
    SUB_STORE = 2'b01,
    SUB_EXEC  = 2'b10,
    SUB_RSVD  = 2'b11
  } sub_op_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_XOR = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    XFER_NONE  = 2'b00,
    XFER_LOAD  = 2'b01,
    XFER_STORE = 2'b10
  } xfer_e;
endpackage

// File: rtl/cop_snoop_decode.sv
module cop_snoop_decode
  import cop_snoop_pkg::*;
#(
  parameter logic [OPC_W-1:0] COP_OPCODE = 4'hF
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_ifetch,
  input  logic [11:0]       word_hi,
  output logic              claim,
  output sub_op_e           sub_op,
  output logic [RIDX_W-1:0] dst_idx,
  output logic [RIDX_W-1:0] src_idx,
  output alu_fn_e           fn
);
  logic [OPC_W-1:0] opc;

  always_comb begin
    opc     = word_hi[11:8];
    sub_op  = sub_op_e'(word_hi[7:6]);
    dst_idx = word_hi[5:4];
    src_idx = word_hi[3:2];
    fn      = alu_fn_e'(word_hi[1:0]);
    claim   = bus_valid && !bus_write && bus_ifetch &&
              (opc == COP_OPCODE) && (sub_op != SUB_RSVD);
  end
endmodule

// File: rtl/cop_snoop_regs.sv
module cop_snoop_regs
  import cop_snoop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [RIDX_W-1:0] raddr_a,
  output logic [WORD_W-1:0] rdata_a,
  input  logic [RIDX_W-1:0] raddr_b,
  output logic [WORD_W-1:0] rdata_b,
  input  logic [RIDX_W-1:0] raddr_c,
  output logic [WORD_W-1:0] rdata_c
);
  logic [WORD_W-1:0] file_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        file_q[g] <= '0;
      else if (we && (waddr == RIDX_W'(g)))
        file_q[g] <= wdata;
    end
  end

  assign rdata_a = file_q[raddr_a];
  assign rdata_b = file_q[raddr_b];
  assign rdata_c = file_q[raddr_c];
endmodule

// File: rtl/cop_snoop_exec.sv
module cop_snoop_exec
  import cop_snoop_pkg::*;
#(
  parameter int EXEC_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  alu_fn_e           fn,
  input  logic [RIDX_W-1:0] dst_idx,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic              busy,
  output logic              done_we,
  output logic [RIDX_W-1:0] done_idx,
  output logic [WORD_W-1:0] done_data
);
  localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  alu_fn_e           fn_q;
  logic [RIDX_W-1:0] dst_q;
  logic [WORD_W-1:0] a_q, b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fn_q  <= FN_ADD;
      dst_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(EXEC_CYCLES);
      fn_q  <= fn;
      dst_q <= dst_idx;
      a_q   <= opa;
      b_q   <= opb;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    unique case (fn_q)
      FN_ADD:  done_data = a_q + b_q;
      FN_SUB:  done_data = a_q - b_q;
      FN_AND:  done_data = a_q & b_q;
      default: done_data = a_q ^ b_q;
    endcase
  end

  assign busy     = (cnt_q != '0);
  assign done_we  = (cnt_q == CNT_W'(1));
  assign done_idx = dst_q;
endmodule

// File: rtl/cop_snoop.sv
module cop_snoop
  import cop_snoop_pkg::*;
#(
  parameter logic [3:0] COP_OPCODE  = 4'hF,
  parameter int         EXEC_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic        bus_ifetch,
  input  logic [15:0] bus_rdata,
  output logic        cop_ack,
  output logic        cop_stall,
  output logic        cop_busy,
  output logic        cop_wdata_en,
  output logic [15:0] cop_wdata
);
  logic              claim, accept, ld_we;
  sub_op_e           sub_op;
  alu_fn_e           fn;
  logic [RIDX_W-1:0] dst_idx, src_idx, xfer_idx_q;
  xfer_e             xfer_q;
  logic [WORD_W-1:0] rd_dst, rd_src, rd_xfer;
  logic              ex_busy, ex_we;
  logic [RIDX_W-1:0] ex_idx;
  logic [WORD_W-1:0] ex_data;
  logic              rf_we;
  logic [RIDX_W-1:0] rf_waddr;
  logic [WORD_W-1:0] rf_wdata;

  cop_snoop_decode #(.COP_OPCODE(COP_OPCODE)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_ifetch(bus_ifetch),
    .word_hi   (bus_rdata[15:4]),
    .claim     (claim),
    .sub_op    (sub_op),
    .dst_idx   (dst_idx),
    .src_idx   (src_idx),
    .fn        (fn)
  );

  assign accept = claim && !ex_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_q     <= XFER_NONE;
      xfer_idx_q <= '0;
    end else if (accept) begin
      unique case (sub_op)
        SUB_LOAD:  begin xfer_q <= XFER_LOAD;  xfer_idx_q <= dst_idx; end
        SUB_STORE: begin xfer_q <= XFER_STORE; xfer_idx_q <= src_idx; end
        default:   xfer_q <= XFER_NONE;
      endcase
    end else if (bus_valid) begin
      xfer_q <= XFER_NONE;
    end
  end

  assign ld_we = (xfer_q == XFER_LOAD) && bus_valid && !bus_write && !bus_ifetch;

  always_comb begin
    rf_we    = ex_we || ld_we;
    rf_waddr = ex_we ? ex_idx  : xfer_idx_q;
    rf_wdata = ex_we ? ex_data : bus_rdata;
  end

  cop_snoop_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (rf_wdata),
    .raddr_a(dst_idx),
    .rdata_a(rd_dst),
    .raddr_b(src_idx),
    .rdata_b(rd_src),
    .raddr_c(xfer_idx_q),
    .rdata_c(rd_xfer)
  );

  cop_snoop_exec #(.EXEC_CYCLES(EXEC_CYCLES)) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept && (sub_op == SUB_EXEC)),
    .fn       (fn),
    .dst_idx  (dst_idx),
    .opa      (rd_dst),
    .opb      (rd_src),
    .busy     (ex_busy),
    .done_we  (ex_we),
    .done_idx (ex_idx),
    .done_data(ex_data)
  );

  always_comb begin
    cop_ack      = claim;
    cop_stall    = claim && ex_busy;
    cop_busy     = ex_busy;
    cop_wdata_en = (xfer_q == XFER_STORE) && bus_valid && bus_write;
    cop_wdata    = cop_wdata_en ? rd_xfer : '0;
  end
endmodule

// File: rtl/cop_snoop_chk.sv
module cop_snoop_chk #(
  parameter int EXEC_CYCLES = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic        bus_ifetch,
  input logic [15:0] bus_rdata,
  input logic        cop_ack,
  input logic        cop_stall,
  input logic        cop_busy,
  input logic        cop_wdata_en,
  input logic [15:0] cop_wdata
);
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !cop_busy) run_len <= 0;
    else                     run_len <= run_len + 1;
  end

  // R2
  ack_only_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_ack |-> (bus_valid && !bus_write && bus_ifetch && bus_rdata[15:12] == 4'hF));

  // R8
  stall_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_stall |-> (cop_ack && cop_busy));

  // R7
  exec_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_ack && !cop_stall && bus_rdata[11:10] == 2'b10) |=> cop_busy);

  // R7
  busy_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cop_busy) |-> (run_len == EXEC_CYCLES));

  // R6
  wdata_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_wdata_en |-> (bus_valid && bus_write));

  // R6
  wdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cop_wdata_en |-> (cop_wdata == 16'h0000));
endmodule

bind cop_snoop cop_snoop_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_ifetch  (bus_ifetch),
  .bus_rdata   (bus_rdata),
  .cop_ack     (cop_ack),
  .cop_stall   (cop_stall),
  .cop_busy    (cop_busy),
  .cop_wdata_en(cop_wdata_en),
  .cop_wdata   (cop_wdata)
);

// File: tb/cop_snoop_tb_top.sv
module cop_snoop_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_ifetch = 1'b0;
  logic [15:0] bus_rdata = 16'h0;
  logic        cop_ack, cop_stall, cop_busy, cop_wdata_en;
  logic [15:0] cop_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int unsigned m_reg [4];
  int m_pend = 0;       // 0 none, 1 load, 2 store
  int m_pidx = 0;
  int m_cnt  = 0;
  int m_fn = 0, m_dst = 0;
  int unsigned m_a = 0, m_b = 0;
  bit last_stall;
  logic [15:0] last_wd;

  always #4 clk = ~clk;  // 125 MHz

  cop_snoop dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_ifetch(bus_ifetch), .bus_rdata(bus_rdata), .cop_ack(cop_ack),
    .cop_stall(cop_stall), .cop_busy(cop_busy), .cop_wdata_en(cop_wdata_en),
    .cop_wdata(cop_wdata)
  );

  task automatic chk(input int unsigned act, input int unsigned exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] enc(input int sub, input int dst, input int src, input int fn);
    return {4'hF, 2'(sub), 2'(dst), 2'(src), 2'(fn), 4'h0};
  endfunction

  function automatic int unsigned alu(input int fn, input int unsigned a, input int unsigned b);
    case (fn)
      0: return (a + b) & 32'hFFFF;
      1: return (a - b) & 32'hFFFF;
      2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  // one bus cycle: drive, compare against model, advance model
  task automatic cyc(input bit v, input bit w, input bit f, input logic [15:0] d);
    bit claim, e_stall, e_wen;
    int unsigned e_wd;
    int n_pend, n_pidx, n_cnt;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_ifetch = f; bus_rdata = d;
    #1;
    claim   = v && !w && f && d[15:12] == 4'hF && d[11:10] != 2'b11;
    e_stall = claim && m_cnt > 0;
    e_wen   = m_pend == 2 && v && w;
    e_wd    = e_wen ? m_reg[m_pidx] : 0;
    chk(cop_ack, claim, "R2 ack");
    chk(cop_stall, e_stall, "R8 stall");
    chk(cop_busy, m_cnt > 0, "R7 busy");
    chk(cop_wdata_en, e_wen, "R6 wdata_en");
    chk(cop_wdata, e_wd, "R6 wdata");
    last_stall = e_stall;
    last_wd = cop_wdata;
    n_pend = m_pend; n_pidx = m_pidx; n_cnt = m_cnt;
    if (claim && m_cnt == 0) begin
      case (int'(d[11:10]))
        0: begin n_pend = 1; n_pidx = d[9:8]; end
        1: begin n_pend = 2; n_pidx = d[7:6]; end
        default: begin
          n_pend = 0; n_cnt = 8; m_fn = d[5:4]; m_dst = d[9:8];
          m_a = m_reg[d[9:8]]; m_b = m_reg[d[7:6]];
        end
      endcase
    end else begin
      if (v) n_pend = 0;
      if (m_cnt > 0) n_cnt = m_cnt - 1;
    end
    @(posedge clk);
    if (m_pend == 1 && v && !w && !f) m_reg[m_pidx] = d;
    if (m_cnt == 1) m_reg[m_dst] = alu(m_fn, m_a, m_b);
    m_pend = n_pend; m_pidx = n_pidx; m_cnt = n_cnt;
  endtask

  task automatic fetch(input logic [15:0] d);
    do cyc(1, 0, 1, d); while (last_stall);
  endtask

  task automatic load(input int r, input logic [15:0] val);
    fetch(enc(0, r, 0, 0));
    cyc(1, 0, 0, val);
  endtask

  task automatic store_chk(input int r, input int unsigned exp, input string tag);
    fetch(enc(1, 0, r, 0));
    cyc(1, 1, 0, 16'h0);
    chk(last_wd, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(cop_ack, 0, "R1 ack"); chk(cop_stall, 0, "R1 stall");
    chk(cop_busy, 0, "R1 busy"); chk(cop_wdata_en, 0, "R1 wdata_en");
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0, 16'h0);
    store_chk(3, 16'h0000, "R1 reg zero");

    // R4 load then R6 store back
    load(0, 16'h1234);
    store_chk(0, 16'h1234, "R4 load r0");
    load(1, 16'h0011);
    load(2, 16'h00FF);

    // R7 add, then R8 store fetched while busy is stalled
    fetch(enc(2, 0, 1, 0));
    store_chk(0, 16'h1245, "R8 stalled store sees add");
    fetch(enc(2, 0, 1, 1));
    store_chk(0, 16'h1234, "R7 sub");
    fetch(enc(2, 0, 2, 2));
    store_chk(0, 16'h0034, "R7 and");
    fetch(enc(2, 0, 2, 3));
    store_chk(0, 16'h00CB, "R7 xor");

    // R9 unclaimed fetches and data cycles during busy window
    fetch(enc(2, 3, 1, 0));
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 1, 16'h1000 + 16'(i));
      chk(last_stall, 0, "R9 foreign fetch");
    end
    cyc(1, 0, 0, 16'hBEEF);
    fetch(enc(3, 0, 0, 0));
    chk(cop_ack, 0, "R3 rsvd sub");
    store_chk(3, 16'h0011, "R7 r3 result");

    // R2 data read carrying the reserved opcode is not claimed
    cyc(1, 0, 0, enc(0, 0, 0, 0));
    chk(cop_ack, 0, "R2 data read");
    store_chk(0, 16'h00CB, "R2 r0 untouched");

    // R3 other opcode
    cyc(1, 0, 1, 16'hE000);
    chk(cop_ack, 0, "R3 other opcode");
    cyc(1, 0, 0, 16'h5555);
    store_chk(0, 16'h00CB, "R3 no load");

    // R5 load slot abandoned by a write, store slot abandoned by a read
    fetch(enc(0, 1, 0, 0));
    cyc(1, 1, 0, 16'hAAAA);
    chk(last_wd, 0, "R5 no drive");
    cyc(1, 0, 0, 16'h7777);
    store_chk(1, 16'h0011, "R5 load dropped");
    fetch(enc(1, 0, 1, 0));
    cyc(1, 0, 0, 16'h0);
    cyc(1, 1, 0, 16'h0);
    chk(last_wd, 0, "R5 store dropped");

    // R4 idle gap before the data read keeps the slot
    fetch(enc(0, 2, 0, 0));
    cyc(0, 0, 0, 16'h0);
    cyc(0, 0, 0, 16'h0);
    cyc(1, 0, 0, 16'h4321);
    store_chk(2, 16'h4321, "R4 gap load");

    repeat (2) cyc(0, 0, 0, 16'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule